// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave side of a four-wire serial control link that gives a host access to a small file of 8-bit configuration registers. The host lowers an active-low select, then clocks in a 16-bit command, most significant bit first. The first bit of the command chooses between a write and a read. The next seven bits give a register address. The last eight bits carry the data byte.

A write frame updates the addressed register once all sixteen bits have arrived. A read frame returns the addressed register on the serial output during the last eight bit times. The output has a separate enable, so a pad can float the line whenever the block is not returning read data.

All of the serial inputs are oversampled in the core clock domain through synchronizers, and every action happens on a detected edge of the serial clock. One bit of one register selects the external filter path, and that bit is brought out directly as a control output. All registers clear on an asynchronous active-low reset, which is released synchronously.

Top module: `sctl_port`

## Requirements
- R1: While and after reset, every implemented register reads 0x00, `ext_filter_sel` is 0 and `sdo_en` is 0.
- R2: A frame is 16 bits, sampled on rising edges of `sclk` while `csel_n` is low, first bit = bit 15. Bit 15 = 0 means write, bits 14:8 are the address and bits 7:0 the data byte. A write updates the addressed register only after the 16th rising edge.
- R3: When bit 15 = 1, `sdo_en` goes high at the falling edge of `sclk` that follows the 8th rising edge, and `sdo` presents D7 at that point. `sdo` then advances one bit per falling edge, so that D7 down to D0 are valid at rising edges 9 to 16.
- R4: `sdo_en` is low at all other times: during the address half of any frame, throughout write frames, while idle, and from the falling edge that follows the 16th rising edge.
- R5: Raising `csel_n` before 16 bits have arrived discards the partial frame: no register changes, `sdo_en` drops and the next frame starts again at bit 15.
- R6: Only addresses 0x10 to 0x17 are implemented. A read of any other address returns 0x00, and a write to it changes nothing, including address 0x54, which differs from 0x14 only in address bit 6.
- R7: `ext_filter_sel` equals bit 0 of register 0x14 and changes only when that register is written.
- R8: Rising edges of `sclk` after the 16th in the same frame are ignored. The write still uses the first 16 bits.
- R9: A read frame never modifies the register it reads, whatever its bits 7:0 carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| csel_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial shift clock, idles low |
| sdi | input | 1 | Serial command and data input |
| sdo | output | 1 | Serial read data, meaningful only while `sdo_en` is high |
| sdo_en | output | 1 | Output enable for the `sdo` pad driver; low means float |
| ext_filter_sel | output | 1 | High selects the external filter path |

## Verification
The bench builds the block with its default parameters. These place the implemented window at 0x10 to 0x17, put the filter select in bit 0 of 0x14, and use two-stage input synchronizers. With that window, an address such as 0x54, which matches 0x14 in its low six bits, shows whether the decode checks every address bit. Addresses below and above the window show whether reads of unimplemented addresses return zero. The serial clock runs at twelve core cycles per period, so the synchronizer latency fits inside each half period and the timing of the read data launch can be checked at the master's sampling edge.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int HDR_W   = 1 + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/sctl_rst_sync.sv
module sctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stg_d[s] = d_i;
    end else begin : g_next
      assign stg_d[s] = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sctl_frame.sv
module sctl_frame
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_act,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_en,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic               sclk_d_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  frame_t             sh_q, sh_d;
  logic [DATA_W-1:0]  tx_q, tx_d;
  logic               en_q, en_d;
  logic               wrq_q, wrq_d;
  logic               rise, fall;

  always_comb begin
    rise  = sclk_s & ~sclk_d_q;
    fall  = ~sclk_s & sclk_d_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    tx_d  = tx_q;
    en_d  = en_q;
    wrq_d = 1'b0;
    if (!sel_act) begin
      cnt_d = '0;
      en_d  = 1'b0;
    end else begin
      if (rise && cnt_q != CNT_FULL) begin
        sh_d  = frame_t'({sh_q[FRAME_W-2:0], sdi_s});
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) wrq_d = ~sh_q[FRAME_W-2];
      end
      if (fall) begin
        if (cnt_q == CNT_HDR && sh_q[HDR_W-1]) begin
          tx_d = rd_data;
          en_d = 1'b1;
        end else if (cnt_q == CNT_FULL) begin
          en_d = 1'b0;
        end else if (en_q) begin
          tx_d = {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      en_q     <= 1'b0;
      wrq_q    <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      tx_q     <= tx_d;
      en_q     <= en_d;
      wrq_q    <= wrq_d;
    end
  end

  // After the header the address sits in the low bits of the shifter.
  assign rd_addr = sh_q[ADDR_W-1:0];
  assign wr_en   = wrq_q;
  assign wr_addr = sh_q.addr;
  assign wr_data = sh_q.data;
  assign sdo     = en_q & tx_q[DATA_W-1];
  assign sdo_en  = en_q;
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int REG_BASE    = 16,
  parameter int NUM_REGS    = 8,
  parameter int BYPASS_ADDR = 20,
  parameter int BYPASS_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              bypass_o
);
  localparam int BYP_IDX = BYPASS_ADDR - REG_BASE;

  logic [DATA_W-1:0] reg_q [NUM_REGS];
  logic [DATA_W-1:0] reg_d [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_comb begin
      reg_d[i] = reg_q[i];
      if (wr_en && wr_addr == ADDR_W'(REG_BASE + i)) reg_d[i] = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[i] <= '0;
      else        reg_q[i] <= reg_d[i];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == ADDR_W'(REG_BASE + i)) rd_data = reg_q[i];
    end
  end

  assign bypass_o = reg_q[BYP_IDX][BYPASS_BIT];
endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int REG_BASE    = 16,
  parameter int NUM_REGS    = 8,
  parameter int BYPASS_ADDR = 20,
  parameter int BYPASS_BIT  = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csel_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en,
  output logic ext_filter_sel
);
  logic              rst_n_s;
  logic [2:0]        pins_s;
  logic              sel_act;
  logic              sclk_s;
  logic              sdi_s;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  bit_cnt;

  sctl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  sctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   ({csel_n, sclk, sdi}),
    .q_o   (pins_s)
  );

  assign sel_act = ~pins_s[2];
  assign sclk_s  = pins_s[1];
  assign sdi_s   = pins_s[0];

  sctl_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .sel_act (sel_act),
    .sclk_s  (sclk_s),
    .sdi_s   (sdi_s),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sdo     (sdo),
    .sdo_en  (sdo_en),
    .bit_cnt (bit_cnt)
  );

  sctl_regfile #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .REG_BASE    (REG_BASE),
    .NUM_REGS    (NUM_REGS),
    .BYPASS_ADDR (BYPASS_ADDR),
    .BYPASS_BIT  (BYPASS_BIT)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .bypass_o (ext_filter_sel)
  );
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk
  import sctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sel_act,
  input logic             sclk_s,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             wr_en,
  input logic             sdo,
  input logic             sdo_en,
  input logic             ext_filter_sel
);
  // R1: outputs quiet while reset is held
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_quiet_r1: assert (!sdo_en && !ext_filter_sel)
        else $error("p_reset_quiet_r1");
    end
  end

  // R2: a register write only follows a full frame
  p_write_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> bit_cnt == CNT_W'(FRAME_W));

  // R3: output driven only in the data half
  p_en_data_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> bit_cnt >= CNT_W'(HDR_W));

  // R3: read data moves only on a serial clock falling edge
  p_sdo_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en && !(!sclk_s && $past(sclk_s))) |=> (!sdo_en || $stable(sdo)));

  // R5: a deselect clears the frame state
  p_abort_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |=> (!sdo_en && bit_cnt == '0));

  // R7: filter select moves only with a write
  p_bypass_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ext_filter_sel));

  // R8: bit counter saturates at a full frame
  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W));
endmodule

bind sctl_port sctl_port_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sel_act        (sel_act),
  .sclk_s         (sclk_s),
  .bit_cnt        (bit_cnt),
  .wr_en          (wr_en),
  .sdo            (sdo),
  .sdo_en         (sdo_en),
  .ext_filter_sel (ext_filter_sel)
);

// File: tb/sctl_port_tb.sv
`timescale 1ns/1ps
module sctl_port_tb;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic csel_n, sclk, sdi;
  logic sdo, sdo_en, ext_filter_sel;
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  always #5 clk = ~clk;

  sctl_port u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .csel_n         (csel_n),
    .sclk           (sclk),
    .sdi            (sdi),
    .sdo            (sdo),
    .sdo_en         (sdo_en),
    .ext_filter_sel (ext_filter_sel)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One frame of nbits; records sdo in data phase and counts enable mismatches.
  task automatic xfer(input logic [15:0] frm, input int nbits,
                      output logic [7:0] rdat, output int en_err);
    bit exp_en;
    rdat   = '0;
    en_err = 0;
    csel_n = 1'b0;
    idle(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      if (i < 16) sdi = frm[15-i];
      else        sdi = 1'b1;
      idle(HALF);
      exp_en = frm[15] && i >= 8 && i < 16;
      if (sdo_en !== exp_en) en_err++;
      if (exp_en) rdat[15-i] = sdo;
      sclk = 1'b1;
      idle(HALF);
    end
    sclk = 1'b0;
    idle(HALF);
    csel_n = 1'b1;
    idle(HALF);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, output int en_err);
    logic [7:0] unused_rd;
    xfer({1'b0, a, d}, 16, unused_rd, en_err);
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d, output int en_err);
    xfer({1'b1, a, 8'h00}, 16, d, en_err);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    int e;
    chk(ext_filter_sel === 1'b0, "R1", "filter select after reset", 16'(ext_filter_sel), 0);
    chk(sdo_en === 1'b0, "R1", "sdo_en after reset", 16'(sdo_en), 0);
    for (int a = 16; a < 24; a++) begin
      rd(7'(a), d, e);
      chk(d === 8'h00, "R1", "register value after reset", 16'(d), 0);
    end
  endtask

  task automatic t_write_read;
    logic [7:0] d;
    int e;
    wr(7'h10, 8'hA5, e);
    chk(e == 0, "R4", "enable during write frame", 16'(e), 0);
    chk(sdo_en === 1'b0, "R4", "enable idle after write", 16'(sdo_en), 0);
    wr(7'h17, 8'h3C, e);
    wr(7'h13, 8'hFF, e);
    rd(7'h10, d, e);
    chk(d === 8'hA5, "R2", "readback 0x10", 16'(d), 16'hA5);
    chk(e == 0, "R3", "enable window on read", 16'(e), 0);
    rd(7'h17, d, e);
    chk(d === 8'h3C, "R2", "readback 0x17", 16'(d), 16'h3C);
    rd(7'h13, d, e);
    chk(d === 8'hFF, "R3", "readback 0x13 all ones", 16'(d), 16'hFF);
    chk(sdo_en === 1'b0, "R4", "enable released after read", 16'(sdo_en), 0);
  endtask

  task automatic t_bypass;
    logic [7:0] d;
    int e;
    wr(7'h14, 8'h01, e);
    chk(ext_filter_sel === 1'b1, "R7", "filter select set", 16'(ext_filter_sel), 1);
    wr(7'h15, 8'hFF, e);
    chk(ext_filter_sel === 1'b1, "R7", "filter select after neighbour write", 16'(ext_filter_sel), 1);
    wr(7'h14, 8'hFE, e);
    chk(ext_filter_sel === 1'b0, "R7", "filter select clear", 16'(ext_filter_sel), 0);
    rd(7'h14, d, e);
    chk(d === 8'hFE, "R7", "readback 0x14", 16'(d), 16'hFE);
  endtask

  task automatic t_unimpl;
    logic [7:0] d;
    int e;
    wr(7'h54, 8'h01, e);
    chk(ext_filter_sel === 1'b0, "R6", "alias write ignored", 16'(ext_filter_sel), 0);
    rd(7'h14, d, e);
    chk(d === 8'hFE, "R6", "0x14 untouched by alias", 16'(d), 16'hFE);
    rd(7'h54, d, e);
    chk(d === 8'h00, "R6", "read alias 0x54", 16'(d), 0);
    wr(7'h0F, 8'h77, e);
    rd(7'h0F, d, e);
    chk(d === 8'h00, "R6", "read 0x0F", 16'(d), 0);
    wr(7'h18, 8'h66, e);
    rd(7'h18, d, e);
    chk(d === 8'h00, "R6", "read 0x18", 16'(d), 0);
    rd(7'h10, d, e);
    chk(d === 8'hA5, "R6", "0x10 untouched", 16'(d), 16'hA5);
  endtask

  task automatic t_abort;
    logic [7:0] d;
    int e;
    xfer({1'b0, 7'h14, 8'h01}, 12, d, e);
    chk(ext_filter_sel === 1'b0, "R5", "aborted write no effect", 16'(ext_filter_sel), 0);
    xfer({1'b1, 7'h10, 8'h00}, 11, d, e);
    chk(sdo_en === 1'b0, "R5", "enable after aborted read", 16'(sdo_en), 0);
    chk(e == 0, "R5", "enable during aborted read", 16'(e), 0);
    rd(7'h14, d, e);
    chk(d === 8'hFE, "R5", "0x14 after aborts", 16'(d), 16'hFE);
  endtask

  task automatic t_extra;
    logic [7:0] d;
    int e;
    xfer({1'b0, 7'h15, 8'h5A}, 20, d, e);
    chk(e == 0, "R8", "enable with extra clocks", 16'(e), 0);
    rd(7'h15, d, e);
    chk(d === 8'h5A, "R8", "write with extra clocks", 16'(d), 16'h5A);
  endtask

  task automatic t_read_keep;
    logic [7:0] d;
    int e;
    xfer({1'b1, 7'h17, 8'hFF}, 16, d, e);
    chk(d === 8'h3C, "R9", "read with data bits set", 16'(d), 16'h3C);
    rd(7'h17, d, e);
    chk(d === 8'h3C, "R9", "register kept after read", 16'(d), 16'h3C);
  endtask

  initial begin
    rst_n  = 1'b0;
    csel_n = 1'b1;
    sclk   = 1'b0;
    sdi    = 1'b0;
    idle(5);
    chk(sdo_en === 1'b0, "R1", "sdo_en during reset", 16'(sdo_en), 0);
    rst_n = 1'b1;
    idle(8);
    t_reset();
    t_write_read();
    t_bypass();
    t_unimpl();
    t_abort();
    t_extra();
    t_read_keep();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule